// File: doc/BRIEF.md
# Single-Channel Fly-By DMA Controller

This block moves a block of items between memory and one peripheral without the processor copying each item. The processor loads four settings through a small register port: the direction, the device address, the first memory address and the item count. It then arms the channel. The data itself never passes through the block. The peripheral and the memory exchange it directly on the shared bus, while the controller supplies the memory address and the paired strobes. This style of transfer is called fly-by.

When the armed channel sees the device request, it asks the processor for the bus with a hold request and waits for the hold grant. Each item then takes three cycles: an address setup cycle, a strobe cycle and a strobe release cycle. During all three cycles the device acknowledge is high. After every item the memory address steps up by one and the count steps down by one. The item in which the count was zero is the last one. After it the bus is given back, the channel disarms itself and a sticky interrupt flag is set. If the device withdraws its request in the middle of a block, the current item completes and the bus is released. The transfer continues from the saved address and count when the request comes back.

Top module: `flyby_dma`

## Requirements
- R1: After reset, all four registers read zero, and hold_req, dev_ack, bus_oe, every strobe and irq are low.
- R2: Register map by reg_addr:
  - 0 is control: bit 0 is the direction, bit 1 is arm, bit 2 reads as the interrupt flag.
  - 1 is the device address.
  - 2 is the current memory address.
  - 3 is the remaining count.
  A write updates the selected register on the next edge, and a read returns it combinationally on reg_rdata.
- R3: hold_req rises on the clock edge after a cycle in which dev_req is high while the channel is armed and idle. It stays high until the block ends or the request is withdrawn.
- R4: bus_oe, dev_ack and the strobes stay low until hold_ack has been sampled high after hold_req rose.
- R5: dev_ack is high in every cycle of every item and in no other cycle, so an N-item block gives exactly 3N cycles of dev_ack.
- R6: Each item is one setup cycle with the address driven and no strobe, then one strobe cycle, then one release cycle. The strobe is one cycle wide, and bus_addr holds its value from setup into the strobe.
- R7: Direction 0 (memory to device) pulses mem_rd and io_wr together. Direction 1 (device to memory) pulses io_rd and mem_wr together. The device address appears on io_addr while the bus is driven.
- R8: The count register holds N-1 for N items. Item k of a block uses memory address start+k. Each item raises the address by one and lowers the count by one.
- R9: The item issued with a count of zero ends the block:
  - hold_req falls on the same edge that sets irq, and arm is cleared.
  - The registers then read count all ones and address start+N.
- R10: If dev_req is low in the release cycle of an item before terminal count, hold_req drops with address and count kept. The block resumes when dev_req returns high.
- R11: irq stays set until a control write with bit 2 at 1. A control write with bit 2 at 0 leaves it set.
- R12: Register writes other than the interrupt clear are ignored while hold_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| dev_req | input | 1 | Peripheral request for service |
| hold_ack | input | 1 | Processor grants the bus |
| hold_req | output | 1 | Request for the bus |
| dev_ack | output | 1 | Peripheral takes part in the current item |
| bus_oe | output | 1 | Controller drives address and strobes |
| bus_addr | output | AW | Memory address, zero when not driven |
| io_addr | output | DEV_W | Device address, zero when not driven |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Device read strobe |
| io_wr | output | 1 | Device write strobe |
| irq | output | 1 | Sticky end-of-block interrupt |

## Verification
The properties assume that once hold_ack is given, it stays high for as long as hold_req is high. The processor never takes the bus back in the middle of a block. The bench's grant model follows this rule. It raises hold_ack after a programmable number of cycles of hold_req and drops it only when hold_req falls. The bench changes dev_req only on falling edges. It programs the channel only while the channel is idle, except in the one case that checks that busy-time writes are ignored.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_GRANT   = 3'd1,
    ST_SETUP   = 3'd2,
    ST_STROBE  = 3'd3,
    ST_RELEASE = 3'd4
  } seq_state_t;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_DEV  = 2'd1;
  localparam logic [1:0] REG_MEM  = 2'd2;
  localparam logic [1:0] REG_CNT  = 2'd3;

  localparam int CTRL_DIR_BIT = 0;
  localparam int CTRL_ARM_BIT = 1;
  localparam int CTRL_IRQ_BIT = 2;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AW     = 16,
  parameter int CW     = 16,
  parameter int DEV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              busy,
  input  logic              step,
  output logic              dir,
  output logic              arm,
  output logic [DEV_W-1:0]  dev_addr,
  output logic [AW-1:0]     mem_addr,
  output logic              cnt_zero,
  output logic              irq
);
  logic [CW-1:0] cnt_q;
  logic          cfg_wr;
  logic          irq_clr;
  logic          last_item;

  assign cfg_wr    = we && !busy;
  assign irq_clr   = we && (addr == REG_CTRL) && wdata[CTRL_IRQ_BIT];
  assign cnt_zero  = (cnt_q == '0);
  assign last_item = step && cnt_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir      <= 1'b0;
      arm      <= 1'b0;
      dev_addr <= '0;
      mem_addr <= '0;
      cnt_q    <= '0;
    end else begin
      if (cfg_wr) begin
        case (addr)
          REG_CTRL: begin
            dir <= wdata[CTRL_DIR_BIT];
            arm <= wdata[CTRL_ARM_BIT];
          end
          REG_DEV: dev_addr <= wdata[DEV_W-1:0];
          REG_MEM: mem_addr <= wdata[AW-1:0];
          default: cnt_q    <= wdata[CW-1:0];
        endcase
      end
      if (step) begin
        mem_addr <= mem_addr + AW'(1);
        cnt_q    <= cnt_q - CW'(1);
        if (cnt_zero) arm <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         irq <= 1'b0;
    else if (last_item) irq <= 1'b1;
    else if (irq_clr)   irq <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      REG_CTRL: begin
        rdata[CTRL_DIR_BIT] = dir;
        rdata[CTRL_ARM_BIT] = arm;
        rdata[CTRL_IRQ_BIT] = irq;
      end
      REG_DEV: rdata[DEV_W-1:0] = dev_addr;
      REG_MEM: rdata[AW-1:0]    = mem_addr;
      default: rdata[CW-1:0]    = cnt_q;
    endcase
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       dev_req,
  input  logic       hold_ack,
  input  logic       cnt_zero,
  output seq_state_t state,
  output logic       step
);
  seq_state_t nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:    if (arm && dev_req) nxt = ST_GRANT;
      ST_GRANT:   if (hold_ack) nxt = ST_SETUP;
      ST_SETUP:   nxt = ST_STROBE;
      ST_STROBE:  nxt = ST_RELEASE;
      ST_RELEASE: begin
        if (cnt_zero)     nxt = ST_IDLE;
        else if (dev_req) nxt = ST_SETUP;
        else              nxt = ST_IDLE;
      end
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign step = (state == ST_RELEASE);
endmodule

// File: rtl/dma_bus_drv.sv
module dma_bus_drv
  import dma_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEV_W = 8
) (
  input  seq_state_t       state,
  input  logic             dir,
  input  logic [AW-1:0]    mem_addr,
  input  logic [DEV_W-1:0] dev_addr,
  output logic             hold_req,
  output logic             dev_ack,
  output logic             bus_oe,
  output logic [AW-1:0]    bus_addr,
  output logic [DEV_W-1:0] io_addr,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             io_rd,
  output logic             io_wr
);
  logic owning;
  logic pulse;

  assign owning   = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_RELEASE);
  assign pulse    = (state == ST_STROBE);
  assign hold_req = (state != ST_IDLE);
  assign dev_ack  = owning;
  assign bus_oe   = owning;
  assign bus_addr = owning ? mem_addr : '0;
  assign io_addr  = owning ? dev_addr : '0;
  assign mem_rd   = pulse && !dir;
  assign io_wr    = pulse && !dir;
  assign io_rd    = pulse && dir;
  assign mem_wr   = pulse && dir;
endmodule

// File: rtl/flyby_dma.sv
module flyby_dma
  import dma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AW     = 16,
  parameter int CW     = 16,
  parameter int DEV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dev_req,
  input  logic              hold_ack,
  output logic              hold_req,
  output logic              dev_ack,
  output logic              bus_oe,
  output logic [AW-1:0]     bus_addr,
  output logic [DEV_W-1:0]  io_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              io_rd,
  output logic              io_wr,
  output logic              irq
);
  seq_state_t       state;
  logic             step;
  logic             dir;
  logic             arm;
  logic             cnt_zero;
  logic [DEV_W-1:0] dev_addr;
  logic [AW-1:0]    mem_addr;
  logic             busy;

  assign busy = (state != ST_IDLE);

  dma_cfg_regs #(.DATA_W(DATA_W), .AW(AW), .CW(CW), .DEV_W(DEV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .step(step),
    .dir(dir), .arm(arm), .dev_addr(dev_addr), .mem_addr(mem_addr),
    .cnt_zero(cnt_zero), .irq(irq)
  );

  dma_seq u_seq (
    .clk(clk), .rst_n(rst_n), .arm(arm), .dev_req(dev_req),
    .hold_ack(hold_ack), .cnt_zero(cnt_zero), .state(state), .step(step)
  );

  dma_bus_drv #(.AW(AW), .DEV_W(DEV_W)) u_bus (
    .state(state), .dir(dir), .mem_addr(mem_addr), .dev_addr(dev_addr),
    .hold_req(hold_req), .dev_ack(dev_ack), .bus_oe(bus_oe),
    .bus_addr(bus_addr), .io_addr(io_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr)
  );
endmodule

// File: rtl/flyby_dma_chk.sv
module flyby_dma_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dev_req,
  input logic          hold_ack,
  input logic          hold_req,
  input logic          dev_ack,
  input logic          bus_oe,
  input logic [AW-1:0] bus_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          io_rd,
  input logic          io_wr,
  input logic          irq
);
  logic any_strobe;
  assign any_strobe = mem_rd || mem_wr || io_rd || io_wr;

  // R3
  hold_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_req) |-> $past(dev_req));

  // R4
  grant_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe || dev_ack || any_strobe) |-> (hold_req && hold_ack));

  // R6
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |=> !any_strobe);

  // R6
  setup_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_strobe) |-> ($past(dev_ack) && $stable(bus_addr)));

  // R7
  strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr}) && $onehot0({io_rd, io_wr}) && (mem_rd == io_wr) && (mem_wr == io_rd));

  // R9
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($fell(hold_req) && !bus_oe));
endmodule

bind flyby_dma flyby_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .hold_ack(hold_ack),
  .hold_req(hold_req), .dev_ack(dev_ack), .bus_oe(bus_oe),
  .bus_addr(bus_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .io_rd(io_rd), .io_wr(io_wr), .irq(irq)
);

// File: tb/flyby_dma_tb.sv
module flyby_dma_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        dev_req = 1'b0;
  logic        hold_ack = 1'b0;
  logic        hold_req, dev_ack, bus_oe, mem_rd, mem_wr, io_rd, io_wr, irq;
  logic [15:0] bus_addr;
  logic [7:0]  io_addr;

  int total = 0;
  int bad = 0;
  int items_seen = 0;
  int ack_cycles = 0;
  int bad_grant = 0;
  int gdel = 0;
  int wait_c = 0;
  bit finished = 0;
  logic [15:0] exp_addr_q[$];
  bit          exp_dir_q[$];
  logic [7:0]  cur_dev = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flyby_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_req(dev_req),
    .hold_ack(hold_ack), .hold_req(hold_req), .dev_ack(dev_ack),
    .bus_oe(bus_oe), .bus_addr(bus_addr), .io_addr(io_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .irq(irq)
  );

  // processor grant model: grants after gdel cycles, holds while requested
  always @(posedge clk) begin
    if (!hold_req) begin
      hold_ack <= 1'b0;
      wait_c   <= 0;
    end else if (wait_c >= gdel) begin
      hold_ack <= 1'b1;
    end else begin
      wait_c <= wait_c + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: pops the expected item each time a strobe cycle appears
  always @(negedge clk) begin
    if (rst_n) begin
      if (dev_ack) ack_cycles++;
      if (mem_rd || mem_wr || io_rd || io_wr) begin
        if (!hold_ack) bad_grant++;
        if (exp_addr_q.size() == 0) begin
          check(1'b0, "R8", "unexpected item", bus_addr, 0);
        end else begin
          logic [15:0] ea;
          bit ed;
          ea = exp_addr_q.pop_front();
          ed = exp_dir_q.pop_front();
          check(bus_addr == ea, "R8", "item address", bus_addr, ea);
          check(io_addr == cur_dev, "R7", "device address", io_addr, cur_dev);
          check({mem_rd, io_wr, io_rd, mem_wr} == (ed ? 4'b0011 : 4'b1100),
                "R7", "strobe pair", {mem_rd, io_wr, io_rd, mem_wr},
                ed ? 4'b0011 : 4'b1100);
        end
        items_seen++;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic run_block(input bit dir, input logic [7:0] dev,
                           input logic [15:0] start, input int n,
                           input int gd, input int drop_after, input bit busy_wr);
    logic [15:0] v;
    gdel = gd;
    cur_dev = dev;
    for (int i = 0; i < n; i++) begin
      exp_addr_q.push_back(start + 16'(i));
      exp_dir_q.push_back(dir);
    end
    wr(2'd1, {8'h00, dev});
    wr(2'd2, start);
    wr(2'd3, 16'(n - 1));
    rd(2'd1, v); check(v == {8'h00, dev}, "R2", "device readback", v, dev);
    rd(2'd2, v); check(v == start, "R2", "memory readback", v, start);
    rd(2'd3, v); check(v == 16'(n - 1), "R2", "count readback", v, n - 1);
    wr(2'd0, {14'd0, 1'b1, dir});
    items_seen = 0;
    ack_cycles = 0;
    bad_grant = 0;
    @(negedge clk);
    dev_req = 1'b1;
    @(negedge clk);
    check(hold_req == 1'b1, "R3", "hold_req after request", hold_req, 1);
    if (busy_wr) begin
      wr(2'd2, 16'h0BAD);   // R12: ignored while busy
      wr(2'd3, 16'h0007);
    end
    if (drop_after > 0) begin
      wait (items_seen == drop_after);
      dev_req = 1'b0;
      repeat (3) @(negedge clk);
      check(hold_req == 1'b0, "R10", "bus released on withdrawn request", hold_req, 0);
      repeat (4) @(negedge clk);
      check(items_seen == drop_after, "R10", "no item while withdrawn", items_seen, drop_after);
      rd(2'd3, v); check(v == 16'(n - 1 - drop_after), "R10", "count kept", v, n - 1 - drop_after);
      rd(2'd2, v); check(v == start + 16'(drop_after), "R10", "address kept", v, start + 16'(drop_after));
      check(irq == 1'b0, "R10", "no irq mid block", irq, 0);
      @(negedge clk);
      dev_req = 1'b1;
    end
    wait (items_seen == n);
    repeat (3) @(negedge clk);
    dev_req = 1'b0;
    check(hold_req == 1'b0, "R9", "hold_req released at end", hold_req, 0);
    check(irq == 1'b1, "R9", "irq raised", irq, 1);
    rd(2'd0, v); check(v[2:1] == 2'b10, "R9", "irq set and arm cleared", v[2:1], 2'b10);
    rd(2'd3, v); check(v == 16'hFFFF, "R9", "count wrapped", v, 16'hFFFF);
    rd(2'd2, v); check(v == start + 16'(n), "R9", "final address", v, start + 16'(n));
    check(ack_cycles == 3 * n, "R5", "dev_ack cycles", ack_cycles, 3 * n);
    check(bad_grant == 0, "R4", "strobe without grant", bad_grant, 0);
    check(exp_addr_q.size() == 0, "R8", "items left over", exp_addr_q.size(), 0);
  endtask

  initial begin : main
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({hold_req, dev_ack, bus_oe, mem_rd, mem_wr, io_rd, io_wr, irq} == 8'd0,
          "R1", "outputs after reset",
          {hold_req, dev_ack, bus_oe, mem_rd, mem_wr, io_rd, io_wr, irq}, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check(v == 16'd0, "R1", "register after reset", v, 0);
    end

    run_block(1'b0, 8'h3C, 16'h0100, 4, 0, 0, 1'b0);

    // R11: write without clear bit keeps irq, clear bit drops it
    wr(2'd0, 16'h0000);
    check(irq == 1'b1, "R11", "irq kept without clear bit", irq, 1);
    wr(2'd0, 16'h0004);
    check(irq == 1'b0, "R11", "irq cleared", irq, 0);

    run_block(1'b1, 8'hA5, 16'h2000, 3, 3, 0, 1'b1);
    wr(2'd0, 16'h0004);
    run_block(1'b0, 8'h11, 16'hFFF0, 1, 1, 0, 1'b0);
    wr(2'd0, 16'h0004);
    run_block(1'b1, 8'h77, 16'h0040, 5, 0, 2, 1'b0);
    wr(2'd0, 16'h0004);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule